// File: doc/BRIEF.md
# Stochastic Bit-Stream Encoder with Pseudo-Random Address Source

This block converts an unsigned 12-bit binary number into a serial stream of single bits whose long-run fraction of ones equals the number divided by 4096. Every generator in the block shares one 32-bit maximal-length linear feedback shift register. The register changes state on every clock and supplies the random select bits. A chain of twelve weighting stages, one per input bit and most significant first, turns those select bits into the weighted stream. A single hand-off record, made of a "choice already made" flag and the chosen bit, passes from each stage to the next.

The same structure is used four more times, each copy fed a fixed fraction instead of a port value. Together these copies give a biased random 4-bit address (0 to 15), which downstream lookup-table weights can index. The raw top bit of the shift register is also brought out, so that neighbouring adders and generators can use it as a fair 0.5-probability select. The data stream is forced to zero while the enable input is low.

Top module: `sbs_gen`

## Requirements
- R1: While `rst` is high, `data_bit` and `addr` are 0 and `rand_bit` equals bit 31 of the seed 32'hACE1_2B57, which is 1.
- R2: The shift register state is never all zero once it is out of reset.
- R3: When `en` is low at a clock edge, `data_bit` is 0 after that edge, whatever `value` holds.
- R4: When `value` is 0, `data_bit` stays 0 on every cycle.
- R5: With `en` high and `value` held at v, the count of ones on `data_bit` over 16384 cycles is within ±2% of 16384 (±327) of v·16384/4096. This holds for v = 4095, for v = 1 and for midrange values.
- R6: Over a long run, address bit k is 1 with a fraction close to a fixed 12-bit weight. The weights are 2728, 3274, 3879 and 4072 (/4096) for k = 0, 1, 2 and 3, with the same ±2% tolerance.
- R7: The state loads the seed 32'hACE1_2B57 on reset. On every later edge it shifts left by one, and the new bit 0 is the XOR of bits 31, 21, 1 and 0 (taps 32, 22, 2, 1). `rand_bit` is bit 31 of the state.
- R8: `rand_bit` is 1 on a fraction of cycles within ±2% of one half.
- R9: `data_bit` is registered. It reflects the `en` and `value` sampled at the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Gates the data value before weighting |
| value | input | 12 | Unsigned number to encode |
| data_bit | output | 1 | Stochastic stream for `value` |
| rand_bit | output | 1 | Raw shift register output bit |
| addr | output | 4 | Biased random address |

## Verification
The clocked assertions assume that reset is held high for at least one rising edge before the block runs. They also assume that `en` and `value` are settled at every rising edge, since the zero-value and disable properties look back one cycle at those inputs. The bench drives every input only on falling edges and starts with several reset cycles. It holds each value steady for a whole counting window, so each window's density is measured against a single expected value.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    localparam int VAL_W     = 12;
    localparam int RNG_W     = 32;
    localparam int ADDR_W    = 4;
    localparam int TAP_STEP  = 5;
    localparam logic [RNG_W-1:0] RNG_SEED = 32'hACE1_2B57;
    // taps 32,22,2,1 -> bit positions 31,21,1,0
    localparam logic [RNG_W-1:0] RNG_TAPS = 32'h8020_0003;

    // record handed from one weighting stage to the next
    typedef struct packed {
        logic taken;   // a more significant stage already chose
        logic bitv;    // bit chosen so far
    } hand_t;

    // shift-register bit feeding stage k of generator g
    function automatic int tap_index(input int g, input int k, input int rw);
        return (k + g * TAP_STEP) % rw;
    endfunction

    // fixed address weights as 12-bit fractions, rescaled to width w
    function automatic int addr_weight(input int k, input int w);
        int f;
        case (k)
            0:       f = 2728;
            1:       f = 3274;
            2:       f = 3879;
            default: f = 4072;
        endcase
        if (w >= 12) return f << (w - 12);
        else         return f >> (12 - w);
    endfunction

endpackage

// File: rtl/sbs_lfsr.sv
module sbs_lfsr #(
    parameter int                 W    = sbs_pkg::RNG_W,
    parameter logic [W-1:0]       SEED = sbs_pkg::RNG_SEED,
    parameter logic [W-1:0]       TAPS = sbs_pkg::RNG_TAPS
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state,
    output logic         msb
);

    logic fb;
    assign fb  = ^(state & TAPS);
    assign msb = state[W-1];

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= {state[W-2:0], fb};
    end

    p_state_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    p_shift_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> state[W-1:1] == $past(state[W-2:0]));

endmodule

// File: rtl/sbs_chain.sv
module sbs_chain #(
    parameter int W = sbs_pkg::VAL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] weight,
    input  logic [W-1:0] sel,     // one random select per bit position
    output logic         bit_out
);
    import sbs_pkg::*;

    hand_t link [W+1];

    assign link[0] = '{taken: 1'b0, bitv: 1'b0};

    generate
        for (genvar j = 0; j < W; j++) begin : g_stage
            localparam int IDX = W - 1 - j;
            always_comb begin
                link[j+1].taken = link[j].taken | sel[IDX];
                link[j+1].bitv  = link[j].taken ? link[j].bitv
                                                : (sel[IDX] & weight[IDX]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) bit_out <= 1'b0;
        else     bit_out <= link[W].bitv;
    end

    p_zero_weight_r4: assert property (@(posedge clk) disable iff (rst)
        $past(weight == '0) |-> !bit_out);

endmodule

// File: rtl/sbs_gen.sv
module sbs_gen #(
    parameter int VW = sbs_pkg::VAL_W,
    parameter int RW = sbs_pkg::RNG_W,
    parameter int AW = sbs_pkg::ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [VW-1:0] value,
    output logic          data_bit,
    output logic          rand_bit,
    output logic [AW-1:0] addr
);
    import sbs_pkg::*;

    localparam int NGEN = AW + 1;   // generator 0 is data, 1..AW are address

    logic [RW-1:0] rng;
    logic [VW-1:0] sel   [NGEN];
    logic [VW-1:0] wt    [NGEN];
    logic [NGEN-1:0] outs;

    sbs_lfsr #(.W(RW)) u_rng (
        .clk   (clk),
        .rst   (rst),
        .state (rng),
        .msb   (rand_bit)
    );

    assign wt[0] = value & {VW{en}};

    generate
        for (genvar g = 0; g < NGEN; g++) begin : g_gen
            for (genvar k = 0; k < VW; k++) begin : g_tap
                localparam int TI = tap_index(g, k, RW);
                assign sel[g][k] = rng[TI];
            end
            if (g > 0) begin : g_const
                assign wt[g] = VW'(addr_weight(g - 1, VW));
            end
            sbs_chain #(.W(VW)) u_chain (
                .clk     (clk),
                .rst     (rst),
                .weight  (wt[g]),
                .sel     (sel[g]),
                .bit_out (outs[g])
            );
        end
    endgenerate

    assign data_bit = outs[0];
    assign addr     = outs[NGEN-1:1];

    p_gate_off_r3: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !data_bit);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!data_bit && addr == '0));

endmodule

// File: tb/sim_sbs_gen.sv
module sim_sbs_gen;

    localparam int WIN = 16384;
    localparam int LIMIT = 195000;
    localparam logic [31:0] SEED = 32'hACE1_2B57;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic [11:0] value = '0;
    logic data_bit, rand_bit;
    logic [3:0] addr;

    int checks = 0, fails = 0, cycles = 0;
    int addr_ones [4];
    int raw_ones = 0, total = 0, model_miss = 0;
    logic [31:0] model;

    always #10 clk = ~clk;

    sbs_gen u0 (
        .clk(clk), .rst(rst), .en(en), .value(value),
        .data_bit(data_bit), .rand_bit(rand_bit), .addr(addr)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    function automatic int expect_ones(input int v, input int n);
        return (v * n) / 4096;
    endfunction

    function automatic int addr_frac(input int k);
        case (k)
            0: return 2728;
            1: return 3274;
            2: return 3879;
            default: return 4072;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit near(input int a, input int e, input int tol);
        return (a >= e - tol) && (a <= e + tol);
    endfunction

    // independent shift register model, R7
    always @(posedge clk) model <= rst ? SEED : step(model);

    always @(negedge clk) begin
        cycles++;
        if (!rst && rand_bit !== model[31]) model_miss++;
        if (cycles > LIMIT) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, LIMIT);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic run_window(input int v, input string tag);
        int ones = 0;
        value = 12'(v);
        en = 1'b1;
        @(negedge clk);
        repeat (WIN) begin
            @(negedge clk);
            if (data_bit) ones++;
            if (rand_bit) raw_ones++;
            for (int k = 0; k < 4; k++) if (addr[k]) addr_ones[k]++;
            total++;
        end
        if (v == 0) check(ones == 0, {tag, " R4 zero value"}, ones, 0);
        else check(near(ones, expect_ones(v, WIN), WIN / 50),
                   {tag, " R5 density"}, ones, expect_ones(v, WIN));
    endtask

    initial begin
        int zeros_seen;
        for (int k = 0; k < 4; k++) addr_ones[k] = 0;
        void'($urandom(32'd1234));

        // R1: reset state
        repeat (3) @(negedge clk);
        check(data_bit == 1'b0, "R1 data in reset", data_bit, 0);
        check(addr == 4'd0, "R1 addr in reset", addr, 0);
        check(rand_bit == SEED[31], "R1 raw bit in reset", rand_bit, SEED[31]);
        rst = 1'b0;

        // R3: disabled with full-scale value stays zero
        value = 12'hFFF;
        en = 1'b0;
        @(negedge clk);
        zeros_seen = 0;
        repeat (200) begin
            @(negedge clk);
            if (data_bit) zeros_seen++;
        end
        check(zeros_seen == 0, "R3 disabled ones", zeros_seen, 0);

        // R9: one register of latency after enabling a full-scale value
        en = 1'b1;
        @(negedge clk);
        zeros_seen = 0;
        repeat (64) begin
            @(negedge clk);
            if (data_bit) zeros_seen++;
        end
        check(zeros_seen >= 60, "R9 enabled stream active", zeros_seen, 64);
        en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(data_bit == 1'b0, "R9 R3 off after one edge", data_bit, 0);

        // R4, R5 directed corners
        run_window(0, "v=0");
        run_window(4095, "v=4095");
        run_window(1, "v=1");
        run_window(2048, "v=2048");
        // R5 random midrange
        for (int i = 0; i < 4; i++) run_window(int'($urandom_range(4000, 50)), "v=rand");

        // R6 address densities
        for (int k = 0; k < 4; k++)
            check(near(addr_ones[k], expect_ones(addr_frac(k), total), total / 50),
                  $sformatf("R6 addr bit %0d", k), addr_ones[k],
                  expect_ones(addr_frac(k), total));

        // R8 raw bit density, R7 sequence, R2 implied by matching model
        check(near(raw_ones, total / 2, total / 50), "R8 raw density", raw_ones, total / 2);
        check(model_miss == 0, "R7 R2 shift sequence", model_miss, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule